// File: doc/BRIEF.md
# Predicated Program Sequencer

This block steers instruction fetch for a wide-issue core. In each cycle that a decoded control instruction is presented, it works out the next fetch address. That address is the following word for straight-line code, or a jump target for a branch, an unconditional jump or a subroutine call. It can also be a saved return address, or the top of a hardware loop when the loop's last word is reached. Nested loops and nested calls are held on two small on-chip stacks. A stack that is asked to go past its capacity or below empty raises a sticky fault flag.

A condition stage turns the four raw arithmetic flags (zero, negative, carry, overflow) into one selected condition. The condition can be a signed comparison, a fixed truth value, or the AND or OR of two chosen flags. The same condition decides conditional branches and acts as a predicate. When the instruction names a group (arithmetic, memory write, immediate load, or all three) and the condition is false, only that group's enable is dropped for the instruction. The fetch address still moves on as usual.

Top module: `pseq_top`

## Requirements
- R1: While rst_n is low, pc is 0, fetch_valid is 0 and stack_err is 0. fetch_valid goes to 1 on the first clock edge after rst_n is released.
- R2: When op_valid is 0, pc keeps its value over the clock edge and all three group enables are 0.
- R3: Opcode 0 (sequential), and the unused codes 6 and 7, load pc+1, which wraps modulo 2^AW, unless R9 applies.
- R4: The condition is chosen by cond_sel. Flags are packed as bit0 zero, bit1 negative, bit2 carry, bit3 overflow, and lt means negative XOR overflow. The codes are: 0 true, 1 zero, 2 not zero, 3 lt, 4 not lt, 5 not zero and not lt, 6 zero or lt, 7 flags[fsel_a] AND flags[fsel_b], 8 flags[fsel_a] OR flags[fsel_b]. Every other code gives false.
- R5: Opcode 1 (branch) loads target when the condition is true and pc+1 when it is false. Opcode 2 (jump) always loads target.
- R6: Opcode 3 (call) loads target and pushes pc+1 on the return stack. Opcode 4 (return) loads the most recently pushed address and removes it.
- R7: A call with RS_DEPTH entries already stored, or a return with none stored, sets stack_err and leaves the stack contents unchanged. The call still jumps, and the failed return loads pc+1. stack_err stays set until reset.
- R8: Opcode 5 (loop setup) pushes a loop level holding start=pc+1, end=target and count=loop_cnt, and loads pc+1. When LP_DEPTH levels are already stored, it sets stack_err and pushes nothing.
- R9: A sequential instruction, or a branch whose condition is false, at pc equal to the innermost loop's end: if count>1, it loads that loop's start and decrements count. Otherwise it removes the level and loads pc+1.
- R10: pred_grp selects the predicated group: 1 arithmetic, 2 memory write, 3 immediate load, 4 all three, and any other value none. With op_valid high, a group's enable is 0 exactly when the group is selected and the condition is false. The pc update is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A control instruction is presented this cycle |
| op | input | 3 | Control opcode |
| target | input | AW | Branch, jump or call target, or loop end address |
| loop_cnt | input | CW | Iteration count for loop setup |
| cond_sel | input | 4 | Condition code |
| fsel_a | input | 2 | First flag index for the AND/OR codes |
| fsel_b | input | 2 | Second flag index for the AND/OR codes |
| pred_grp | input | 3 | Predicated group selector |
| flags | input | 4 | Raw operator flags {overflow, carry, negative, zero} |
| pc | output | AW | Current fetch address |
| fetch_valid | output | 1 | Fetch address is meaningful |
| en_arith | output | 1 | Arithmetic group enable |
| en_memwr | output | 1 | Memory-write group enable |
| en_imm | output | 1 | Immediate-load group enable |
| stack_err | output | 1 | Sticky stack overflow/underflow fault |

## Verification
The hardest situation to reach is a full return stack that is then asked for one more call. The stack must keep its old contents, so the next return has to produce the eighth saved address and not the ninth. The stimulus gets there with a chain of calls, each jumping ten words ahead, so every saved address is distinct and known. After the refused call, one return shows whether the top entry survived. Loop wind-back is reached by placing a short body right after a loop setup and stepping through every pass until the level is removed.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam logic [2:0] OP_SEQ  = 3'd0;
  localparam logic [2:0] OP_BR   = 3'd1;
  localparam logic [2:0] OP_JMP  = 3'd2;
  localparam logic [2:0] OP_CALL = 3'd3;
  localparam logic [2:0] OP_RET  = 3'd4;
  localparam logic [2:0] OP_LOOP = 3'd5;

  localparam int FZ = 0;
  localparam int FN = 1;
  localparam int FC = 2;
  localparam int FV = 3;

  // compound condition from raw flags
  function automatic logic cond_eval(input logic [3:0] sel, input logic [3:0] f,
                                     input logic [1:0] sa, input logic [1:0] sb);
    logic lt;
    lt = f[FN] ^ f[FV];
    case (sel)
      4'd0: return 1'b1;
      4'd1: return f[FZ];
      4'd2: return !f[FZ];
      4'd3: return lt;
      4'd4: return !lt;
      4'd5: return !f[FZ] && !lt;
      4'd6: return f[FZ] || lt;
      4'd7: return f[sa] && f[sb];
      4'd8: return f[sa] || f[sb];
      default: return 1'b0;
    endcase
  endfunction

  // group mask {imm, memwr, arith}
  function automatic logic [2:0] grp_mask(input logic [2:0] g);
    case (g)
      3'd1: return 3'b001;
      3'd2: return 3'b010;
      3'd3: return 3'b100;
      3'd4: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/pseq_cond.sv
module pseq_cond
  import pseq_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  logic [3:0] flags,
  input  logic [1:0] fsel_a,
  input  logic [1:0] fsel_b,
  input  logic [2:0] pred_grp,
  output logic       cond_ok,
  output logic [2:0] kill
);
  always_comb begin
    cond_ok = cond_eval(cond_sel, flags, fsel_a, fsel_b);
    kill    = grp_mask(pred_grp) & {3{~cond_ok}};
  end
endmodule

// File: rtl/pseq_lifo.sv
module pseq_lifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         rep,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [CNW-1:0] cnt;
  logic [IW-1:0]  top_idx;
  logic [IW-1:0]  wr_idx;

  assign top_idx = IW'(cnt - CNW'(1));
  assign wr_idx  = IW'(cnt);
  assign full    = (cnt == CNW'(DEPTH));
  assign empty   = (cnt == '0);
  assign top     = mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[wr_idx] <= din;
      cnt <= cnt + CNW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNW'(1);
    end else if (rep && !empty) begin
      mem[top_idx] <= din;
    end
  end
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CW       = 8,
  parameter int RS_DEPTH = 8,
  parameter int LP_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] loop_cnt,
  input  logic [3:0]    cond_sel,
  input  logic [1:0]    fsel_a,
  input  logic [1:0]    fsel_b,
  input  logic [2:0]    pred_grp,
  input  logic [3:0]    flags,
  output logic [AW-1:0] pc,
  output logic          fetch_valid,
  output logic          en_arith,
  output logic          en_memwr,
  output logic          en_imm,
  output logic          stack_err
);
  typedef struct packed {
    logic [AW-1:0] lstart;
    logic [AW-1:0] lend;
    logic [CW-1:0] lcnt;
  } loop_t;
  localparam int LW = $bits(loop_t);

  logic [AW-1:0] seq_pc, next_pc, rs_top;
  logic          cond_ok;
  logic [2:0]    kill;
  logic          is_seq, flow_seq;
  logic          do_call, do_ret, lp_new;
  logic          rs_push, rs_pop, rs_full, rs_empty;
  logic          lp_push, lp_pop, lp_rep, lp_full, lp_empty;
  logic          loop_hit, loop_back, stk_fault;
  loop_t         lp_top, lp_din;

  pseq_cond u_cond (
    .cond_sel(cond_sel), .flags(flags), .fsel_a(fsel_a), .fsel_b(fsel_b),
    .pred_grp(pred_grp), .cond_ok(cond_ok), .kill(kill)
  );

  assign seq_pc    = pc + AW'(1);
  assign is_seq    = (op == OP_SEQ) || (op > OP_LOOP);
  assign flow_seq  = is_seq || ((op == OP_BR) && !cond_ok);
  assign do_call   = op_valid && (op == OP_CALL);
  assign do_ret    = op_valid && (op == OP_RET);
  assign lp_new    = op_valid && (op == OP_LOOP);
  assign rs_push   = do_call && !rs_full;
  assign rs_pop    = do_ret && !rs_empty;
  assign lp_push   = lp_new && !lp_full;
  assign loop_hit  = op_valid && flow_seq && !lp_empty && (lp_top.lend == pc);
  assign loop_back = loop_hit && (lp_top.lcnt > CW'(1));
  assign lp_rep    = loop_back;
  assign lp_pop    = loop_hit && !loop_back;
  assign stk_fault = (do_call && rs_full) || (do_ret && rs_empty) || (lp_new && lp_full);

  always_comb begin
    if (lp_push) lp_din = '{lstart: seq_pc, lend: target, lcnt: loop_cnt};
    else         lp_din = '{lstart: lp_top.lstart, lend: lp_top.lend,
                            lcnt: lp_top.lcnt - CW'(1)};
  end

  pseq_lifo #(.W(AW), .DEPTH(RS_DEPTH)) u_rstack (
    .clk(clk), .rst_n(rst_n), .push(rs_push), .pop(rs_pop), .rep(1'b0),
    .din(seq_pc), .top(rs_top), .full(rs_full), .empty(rs_empty)
  );

  pseq_lifo #(.W(LW), .DEPTH(LP_DEPTH)) u_lstack (
    .clk(clk), .rst_n(rst_n), .push(lp_push), .pop(lp_pop), .rep(lp_rep),
    .din(lp_din), .top(lp_top), .full(lp_full), .empty(lp_empty)
  );

  always_comb begin
    next_pc = pc;
    if (op_valid) begin
      case (op)
        OP_BR:   next_pc = cond_ok ? target : (loop_back ? lp_top.lstart : seq_pc);
        OP_JMP:  next_pc = target;
        OP_CALL: next_pc = target;
        OP_RET:  next_pc = rs_empty ? seq_pc : rs_top;
        OP_LOOP: next_pc = seq_pc;
        default: next_pc = loop_back ? lp_top.lstart : seq_pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= '0;
      fetch_valid <= 1'b0;
      stack_err   <= 1'b0;
    end else begin
      pc          <= next_pc;
      fetch_valid <= 1'b1;
      if (stk_fault) stack_err <= 1'b1;
    end
  end

  assign en_arith = op_valid && !kill[0];
  assign en_memwr = op_valid && !kill[1];
  assign en_imm   = op_valid && !kill[2];
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk
  import pseq_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op,
  input logic [AW-1:0] target,
  input logic [2:0]    pred_grp,
  input logic          cond_ok,
  input logic [AW-1:0] pc,
  input logic          en_arith,
  input logic          en_memwr,
  input logic          en_imm,
  input logic          stack_err,
  input logic          rs_full,
  input logic          rs_empty,
  input logic          loop_back,
  input logic [AW-1:0] loop_start
);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> pc == $past(pc));
  // R2
  stall_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !en_arith && !en_memwr && !en_imm);
  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_JMP) |=> pc == $past(target));
  // R6
  call_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CALL) |=> pc == $past(target));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
  // R7
  overflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_CALL && rs_full) |=> stack_err);
  // R7
  underflow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_RET && rs_empty) |=> stack_err);
  // R9
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |=> pc == $past(loop_start));
  // R10
  pred_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && pred_grp == 3'd4 && !cond_ok) |-> !en_arith && !en_memwr && !en_imm);
endmodule

bind pseq_top pseq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .target(target),
  .pred_grp(pred_grp), .cond_ok(cond_ok), .pc(pc), .en_arith(en_arith),
  .en_memwr(en_memwr), .en_imm(en_imm), .stack_err(stack_err),
  .rs_full(rs_full), .rs_empty(rs_empty), .loop_back(loop_back),
  .loop_start(lp_top.lstart)
);

// File: tb/pseq_top_test.sv
module pseq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] target = '0;
  logic [CW-1:0] loop_cnt = '0;
  logic [3:0]    cond_sel = '0;
  logic [1:0]    fsel_a = '0;
  logic [1:0]    fsel_b = '0;
  logic [2:0]    pred_grp = '0;
  logic [3:0]    flags = '0;
  logic [AW-1:0] pc;
  logic          fetch_valid, en_arith, en_memwr, en_imm, stack_err;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pseq_top #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .target(target),
    .loop_cnt(loop_cnt), .cond_sel(cond_sel), .fsel_a(fsel_a), .fsel_b(fsel_b),
    .pred_grp(pred_grp), .flags(flags), .pc(pc), .fetch_valid(fetch_valid),
    .en_arith(en_arith), .en_memwr(en_memwr), .en_imm(en_imm), .stack_err(stack_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one instruction at a falling edge, return at the next falling edge
  task automatic issue(input logic [2:0] o, input int tgt, input logic [3:0] cs,
                       input logic [3:0] fl);
    op_valid = 1'b1; op = o; target = AW'(tgt); cond_sel = cs; flags = fl;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; op_valid = 1'b0; pred_grp = '0; fsel_a = '0; fsel_b = '0;
    loop_cnt = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; op_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 pc in reset", int'(pc), 0);
    chk("R1 fetch_valid in reset", int'(fetch_valid), 0);
    chk("R1 stack_err in reset", int'(stack_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fetch_valid after release", int'(fetch_valid), 1);
  endtask

  task automatic t_stall;
    do_reset();
    issue(3'd0, 0, 4'd0, 4'd0);
    issue(3'd0, 0, 4'd0, 4'd0);
    op_valid = 1'b0; op = 3'd2; target = 12'd77;
    #1;
    chk("R2 enables low when idle", int'({en_arith, en_memwr, en_imm}), 0);
    @(negedge clk); @(negedge clk);
    chk("R2 pc holds when idle", int'(pc), 2);
  endtask

  task automatic t_seq;
    do_reset();
    issue(3'd0, 0, 4'd0, 4'd0);
    issue(3'd6, 0, 4'd0, 4'd0);
    issue(3'd7, 0, 4'd0, 4'd0);
    chk("R3 sequential advance", int'(pc), 3);
    issue(3'd2, 4095, 4'd0, 4'd0);
    issue(3'd0, 0, 4'd0, 4'd0);
    chk("R3 wrap to zero", int'(pc), 0);
  endtask

  task automatic br_case(input string tag, input logic [3:0] cs, input logic [3:0] fl,
                         input logic [1:0] a, input logic [1:0] b, input bit taken);
    int start;
    start = int'(pc);
    fsel_a = a; fsel_b = b;
    issue(3'd1, (start + 40) % 4096, cs, fl);
    chk(tag, int'(pc), taken ? (start + 40) % 4096 : (start + 1) % 4096);
  endtask

  task automatic t_branch;
    do_reset();
    br_case("R4 R5 eq taken",       4'd1,  4'b0001, 2'd0, 2'd0, 1'b1);
    br_case("R4 R5 ne not taken",   4'd2,  4'b0001, 2'd0, 2'd0, 1'b0);
    br_case("R4 R5 lt taken",       4'd3,  4'b0010, 2'd0, 2'd0, 1'b1);
    br_case("R4 R5 ge N=V taken",   4'd4,  4'b1010, 2'd0, 2'd0, 1'b1);
    br_case("R4 R5 gt taken",       4'd5,  4'b0000, 2'd0, 2'd0, 1'b1);
    br_case("R4 R5 gt zero no",     4'd5,  4'b0001, 2'd0, 2'd0, 1'b0);
    br_case("R4 R5 le zero taken",  4'd6,  4'b0001, 2'd0, 2'd0, 1'b1);
    br_case("R4 R5 C and V no",     4'd7,  4'b0100, 2'd2, 2'd3, 1'b0);
    br_case("R4 R5 C or V taken",   4'd8,  4'b0100, 2'd2, 2'd3, 1'b1);
    br_case("R4 R5 never",          4'd15, 4'b1111, 2'd0, 2'd0, 1'b0);
    br_case("R4 R5 always",         4'd0,  4'b0000, 2'd0, 2'd0, 1'b1);
    issue(3'd2, 500, 4'd15, 4'd0);
    chk("R5 jump ignores false condition", int'(pc), 500);
  endtask

  task automatic t_call;
    do_reset();
    issue(3'd0, 0, 4'd0, 4'd0);
    issue(3'd3, 300, 4'd0, 4'd0);
    chk("R6 call target", int'(pc), 300);
    issue(3'd0, 0, 4'd0, 4'd0);
    issue(3'd4, 0, 4'd0, 4'd0);
    chk("R6 return address", int'(pc), 2);
    chk("R7 no fault on balanced use", int'(stack_err), 0);
  endtask

  task automatic t_underflow;
    do_reset();
    issue(3'd0, 0, 4'd0, 4'd0);
    issue(3'd4, 0, 4'd0, 4'd0);
    chk("R7 empty return loads pc+1", int'(pc), 2);
    chk("R7 underflow flag", int'(stack_err), 1);
    issue(3'd0, 0, 4'd0, 4'd0);
    chk("R7 flag sticky", int'(stack_err), 1);
  endtask

  task automatic t_overflow;
    do_reset();
    for (int i = 0; i < 8; i++) issue(3'd3, int'(pc) + 10, 4'd0, 4'd0);
    chk("R7 eight calls no fault", int'(stack_err), 0);
    issue(3'd3, 90, 4'd0, 4'd0);
    chk("R7 overflow call still jumps", int'(pc), 90);
    chk("R7 overflow flag", int'(stack_err), 1);
    issue(3'd4, 0, 4'd0, 4'd0);
    chk("R7 top survives overflow", int'(pc), 71);
    issue(3'd4, 0, 4'd0, 4'd0);
    chk("R6 second pop", int'(pc), 61);
  endtask

  task automatic t_loop;
    int exp_seq [7] = '{1, 2, 1, 2, 1, 2, 3};
    do_reset();
    loop_cnt = 8'd3;
    issue(3'd5, 2, 4'd0, 4'd0);
    chk("R8 loop setup advances", int'(pc), exp_seq[0]);
    for (int i = 1; i < 7; i++) begin
      issue(3'd0, 0, 4'd0, 4'd0);
      chk("R9 loop pass address", int'(pc), exp_seq[i]);
    end
    issue(3'd0, 0, 4'd0, 4'd0);
    chk("R9 level removed after last pass", int'(pc), 4);
    chk("R8 no fault", int'(stack_err), 0);
  endtask

  task automatic t_loop_ovf;
    do_reset();
    loop_cnt = 8'd2;
    for (int i = 0; i < 4; i++) issue(3'd5, 1000, 4'd0, 4'd0);
    chk("R8 four levels no fault", int'(stack_err), 0);
    issue(3'd5, 1000, 4'd0, 4'd0);
    chk("R8 fifth level faults", int'(stack_err), 1);
  endtask

  task automatic pred_case(input string tag, input logic [2:0] g, input logic [3:0] cs,
                           input int exp_en);
    int start;
    start = int'(pc);
    op_valid = 1'b1; op = 3'd0; pred_grp = g; cond_sel = cs; flags = 4'd0;
    #1;
    chk(tag, int'({en_imm, en_memwr, en_arith}), exp_en);
    @(negedge clk);
    chk("R10 pc advances when predicated", int'(pc), start + 1);
  endtask

  task automatic t_pred;
    do_reset();
    pred_case("R10 arith off",      3'd1, 4'd15, 3'b110);
    pred_case("R10 memwr off",      3'd2, 4'd15, 3'b101);
    pred_case("R10 imm off",        3'd3, 4'd15, 3'b011);
    pred_case("R10 all off",        3'd4, 4'd15, 3'b000);
    pred_case("R10 all on true",    3'd4, 4'd0,  3'b111);
    pred_case("R10 none selected",  3'd0, 4'd15, 3'b111);
    pred_grp = '0;
  endtask

  initial begin
    t_reset();
    t_stall();
    t_seq();
    t_branch();
    t_call();
    t_underflow();
    t_overflow();
    t_loop();
    t_loop_ovf();
    t_pred();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule